// File: doc/BRIEF.md
# Link Register Controller for Cacheable LL/SC

This block sits on the first-level cache side of a core. It turns the core's load-linked (LL) and store-conditional (SC) instructions into memory traffic for a cacheable atomic scheme. It keeps one link register: a valid flag, the linked address, the value returned to the core, and a flag that marks a 64-bit link.

An LL that finds a live link with the same address and size is answered from the link register and causes no memory access. Any other LL opens a new link and issues a plain read to the memory side. The block keeps the returned data and passes it to the core. An SC that matches the link sends a compare-and-swap request to the memory side. The request carries the old data first and then the new data. The memory reports a one-bit status, which the block maps to the core's success convention. An SC that does not match fails at once without a memory access. Every SC ends the link.

Invalidate and update messages from the coherence side are visible at the ports but never touch the link register. The core side handles one request at a time: a request is accepted only while the block is idle, and each request gets exactly one single-cycle response.

Top module: `linkreg_ctrl`

## Requirements
- R1: After reset the link is empty. `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_cmd_valid` are 0.
- R2: An LL whose address and size match a live link is answered in the cycle right after acceptance, with the stored data, and produces no memory command.
- R3: Any other LL opens a link at that address and size. It issues one read command (`mem_cmd_kind`=0, `mem_cmd_last`=1, data 0). The memory reply is returned to the core and kept in the link. For a 32-bit LL, the upper 32 bits of the reply are replaced with zero.
- R4: An SC that matches a live link in address and size sends a compare-and-swap command with `mem_cmd_kind`=1. A 32-bit SC sends 2 flits: old[31:0], then new[31:0]. A 64-bit SC sends 4 flits: old[31:0], old[63:32], new[31:0], new[63:32]. `mem_cmd_last` is set only on the final flit, and every flit carries the link address and size.
- R5: An SC that finds no live link, a different address, or a different size is answered with the failure code in the cycle right after acceptance, and produces no memory command.
- R6: Every accepted SC clears the link, whether it succeeds or fails. A second SC to the same address therefore fails locally.
- R7: Pulses on `coh_inval` or `coh_update` leave the link unchanged. An LL to the linked address made after such pulses is still answered locally.
- R8: For an SC, bit 0 of the memory reply is 0 on success and 1 on failure. When `SUCCESS_NONZERO`=1 (the default), the core receives 1 for success and 0 for failure. When it is 0, the status bit is passed through unchanged. In both cases the result is zero-extended to 64 bits.
- R9: While `mem_cmd_valid` is 1 and `mem_cmd_ready` is 0, the command stays valid and its flit, kind and last flag do not change.
- R10: A request is accepted only while `cpu_req_ready` is 1. `cpu_req_ready` is 0 whenever a response is being given, and `cpu_rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Core request present |
| cpu_req_ready | output | 1 | Block idle, request taken this cycle |
| cpu_req_sc | input | 1 | 1 = SC, 0 = LL |
| cpu_req_long | input | 1 | 1 = 64-bit access |
| cpu_req_addr | input | ADDR_W | Access address |
| cpu_req_wdata | input | 2*WORD_W | SC store data |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_data | output | 2*WORD_W | LL data or SC result |
| mem_cmd_valid | output | 1 | Memory command flit valid |
| mem_cmd_ready | input | 1 | Memory side takes the flit |
| mem_cmd_kind | output | 1 | 0 = read, 1 = compare-and-swap |
| mem_cmd_addr | output | ADDR_W | Command address |
| mem_cmd_long | output | 1 | 64-bit command |
| mem_cmd_data | output | WORD_W | Flit payload |
| mem_cmd_last | output | 1 | Final flit of the command |
| mem_rsp_valid | input | 1 | Memory reply pulse |
| mem_rsp_data | input | 2*WORD_W | Read data, or status in bit 0 |
| coh_inval | input | 1 | Coherence invalidate (no effect on link) |
| coh_update | input | 1 | Coherence update (no effect on link) |

## Verification
The checker watches these properties on every cycle:
- an SC always ends the link, and an LL always opens it at the requested address;
- an LL hit and an SC miss are answered locally, one cycle after acceptance, with no command issued;
- coherence pulses leave the link valid flag and address alone;
- a stalled flit holds its value;
- each response is a single-cycle pulse while the block is not ready.

Some behaviour only the bench scenarios can show:
- the flit order and payloads;
- the 32-bit masking of read data;
- the compare-and-swap outcome against a changed memory value;
- the mapping of the memory status to the core's convention.

The bench checks these against a reference model of the link and of the memory.

// File: rtl/linkreg_pkg.sv
package linkreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_SC_SEND = 3'd3,
    ST_SC_WAIT = 3'd4,
    ST_RESP    = 3'd5
  } lr_state_e;

  localparam logic CMD_READ = 1'b0;
  localparam logic CMD_CAS  = 1'b1;

  localparam int FLITS_LONG  = 4;
  localparam int FLITS_SHORT = 2;

endpackage

// File: rtl/linkreg_store.sv
module linkreg_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              set_long,
  input  logic              data_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_long,
  output logic              probe_match,
  output logic              valid_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              long_q,
  output logic [DATA_W-1:0] data_q
);

  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic              long_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    long_d  = long_q;
    data_d  = data_q;
    if (set_en) begin
      valid_d = 1'b1;
      addr_d  = set_addr;
      long_d  = set_long;
    end else if (clr_en) begin
      valid_d = 1'b0;
    end
    if (data_en) begin
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      long_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      long_q  <= long_d;
      data_q  <= data_d;
    end
  end

  assign probe_match = valid_q && (addr_q == probe_addr) && (long_q == probe_long);

endmodule

// File: rtl/sc_flit_builder.sv
module sc_flit_builder #(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [2*WORD_W-1:0] old_data,
  input  logic [2*WORD_W-1:0] new_data,
  input  logic                is_long,
  input  logic [IDX_W-1:0]    idx,
  output logic [WORD_W-1:0]   flit,
  output logic                last
);

  logic [WORD_W-1:0] long_slot [SLOTS];
  logic [WORD_W-1:0] short_flit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < SLOTS/2) begin : g_old
      assign long_slot[g] = old_data[g*WORD_W +: WORD_W];
    end else begin : g_new
      assign long_slot[g] = new_data[(g-SLOTS/2)*WORD_W +: WORD_W];
    end
  end

  assign short_flit = idx[0] ? new_data[WORD_W-1:0] : old_data[WORD_W-1:0];
  assign flit = is_long ? long_slot[idx] : short_flit;
  assign last = is_long ? (idx == IDX_W'(SLOTS-1)) : (idx == IDX_W'(SLOTS/2-1));

endmodule

// File: rtl/status_xlate.sv
module status_xlate #(
  parameter int  OUT_W           = 64,
  parameter bit  SUCCESS_NONZERO = 1'b1
) (
  input  logic             mem_fail,
  output logic [OUT_W-1:0] result
);

  if (SUCCESS_NONZERO) begin : g_invert
    assign result = {{(OUT_W-1){1'b0}}, ~mem_fail};
  end else begin : g_pass
    assign result = {{(OUT_W-1){1'b0}}, mem_fail};
  end

endmodule

// File: rtl/linkreg_ctrl.sv
module linkreg_ctrl
  import linkreg_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int WORD_W          = 32,
  parameter bit SUCCESS_NONZERO = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_req_sc,
  input  logic                cpu_req_long,
  input  logic [ADDR_W-1:0]   cpu_req_addr,
  input  logic [2*WORD_W-1:0] cpu_req_wdata,
  output logic                cpu_rsp_valid,
  output logic [2*WORD_W-1:0] cpu_rsp_data,
  output logic                mem_cmd_valid,
  input  logic                mem_cmd_ready,
  output logic                mem_cmd_kind,
  output logic [ADDR_W-1:0]   mem_cmd_addr,
  output logic                mem_cmd_long,
  output logic [WORD_W-1:0]   mem_cmd_data,
  output logic                mem_cmd_last,
  input  logic                mem_rsp_valid,
  input  logic [2*WORD_W-1:0] mem_rsp_data,
  input  logic                coh_inval,
  input  logic                coh_update
);

  localparam int DATA_W = 2*WORD_W;
  localparam int IDX_W  = $clog2(FLITS_LONG);

  lr_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rsp_q, rsp_d;

  logic              req_acc;
  logic              link_match;
  logic              link_valid;
  logic [ADDR_W-1:0] link_addr;
  logic              link_long;
  logic [DATA_W-1:0] link_data;
  logic              set_en, clr_en, data_en, wdata_en;
  logic [DATA_W-1:0] rd_masked;
  logic [WORD_W-1:0] flit_w;
  logic              flit_last_w;
  logic [DATA_W-1:0] cas_result;
  logic [DATA_W-1:0] fail_code;
  logic              coh_unused;

  // Coherence traffic deliberately has no path into the link register.
  assign coh_unused = coh_inval | coh_update;

  assign req_acc = cpu_req_valid && (state_q == ST_IDLE);

  linkreg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .set_addr   (cpu_req_addr),
    .set_long   (cpu_req_long),
    .data_en    (data_en),
    .data_in    (rd_masked),
    .probe_addr (cpu_req_addr),
    .probe_long (cpu_req_long),
    .probe_match(link_match),
    .valid_q    (link_valid),
    .addr_q     (link_addr),
    .long_q     (link_long),
    .data_q     (link_data)
  );

  sc_flit_builder #(.WORD_W(WORD_W), .SLOTS(FLITS_LONG)) u_flits (
    .old_data(link_data),
    .new_data(wdata_q),
    .is_long (link_long),
    .idx     (idx_q),
    .flit    (flit_w),
    .last    (flit_last_w)
  );

  status_xlate #(.OUT_W(DATA_W), .SUCCESS_NONZERO(SUCCESS_NONZERO)) u_xlate_mem (
    .mem_fail(mem_rsp_data[0]),
    .result  (cas_result)
  );

  status_xlate #(.OUT_W(DATA_W), .SUCCESS_NONZERO(SUCCESS_NONZERO)) u_xlate_local (
    .mem_fail(1'b1),
    .result  (fail_code)
  );

  assign rd_masked = link_long ? mem_rsp_data
                               : {{WORD_W{1'b0}}, mem_rsp_data[WORD_W-1:0]};

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    wdata_d  = wdata_q;
    rsp_d    = rsp_q;
    set_en   = 1'b0;
    clr_en   = 1'b0;
    data_en  = 1'b0;
    wdata_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_acc) begin
          if (!cpu_req_sc) begin
            if (link_match) begin
              rsp_d   = link_data;
              state_d = ST_RESP;
            end else begin
              set_en  = 1'b1;
              state_d = ST_RD_REQ;
            end
          end else begin
            clr_en = 1'b1;
            if (link_match) begin
              wdata_en = 1'b1;
              idx_d    = '0;
              state_d  = ST_SC_SEND;
            end else begin
              rsp_d   = fail_code;
              state_d = ST_RESP;
            end
          end
        end
      end
      ST_RD_REQ: begin
        if (mem_cmd_ready) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          data_en = 1'b1;
          rsp_d   = rd_masked;
          state_d = ST_RESP;
        end
      end
      ST_SC_SEND: begin
        if (mem_cmd_ready) begin
          if (flit_last_w) state_d = ST_SC_WAIT;
          else             idx_d   = idx_q + IDX_W'(1);
        end
      end
      ST_SC_WAIT: begin
        if (mem_rsp_valid) begin
          rsp_d   = cas_result;
          state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
    if (wdata_en) wdata_d = cpu_req_wdata;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wdata_q <= wdata_d;
      rsp_q   <= rsp_d;
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_data  = rsp_q;

  assign mem_cmd_valid = (state_q == ST_RD_REQ) || (state_q == ST_SC_SEND);
  assign mem_cmd_kind  = (state_q == ST_SC_SEND) ? CMD_CAS : CMD_READ;
  assign mem_cmd_addr  = link_addr;
  assign mem_cmd_long  = link_long;
  assign mem_cmd_data  = (state_q == ST_SC_SEND) ? flit_w : '0;
  assign mem_cmd_last  = (state_q == ST_SC_SEND) ? flit_last_w : 1'b1;

endmodule

// File: rtl/linkreg_ctrl_chk.sv
module linkreg_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_sc,
  input logic              cpu_req_long,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_rsp_valid,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic              mem_cmd_kind,
  input logic [WORD_W-1:0] mem_cmd_data,
  input logic              mem_cmd_last,
  input logic              coh_inval,
  input logic              coh_update,
  input logic              link_valid,
  input logic [ADDR_W-1:0] link_addr,
  input logic              link_long
);

  logic acc;
  logic same_link;
  assign acc       = cpu_req_valid && cpu_req_ready;
  assign same_link = link_valid && (link_addr == cpu_req_addr) && (link_long == cpu_req_long);

  p_ll_hit_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cpu_req_sc && same_link |=> cpu_rsp_valid && !mem_cmd_valid);

  p_ll_opens_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cpu_req_sc |=> link_valid && (link_addr == $past(cpu_req_addr)));

  p_sc_miss_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cpu_req_sc && !same_link |=> cpu_rsp_valid && !mem_cmd_valid);

  p_sc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cpu_req_sc |=> !link_valid);

  p_coh_keeps_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_inval || coh_update) && !acc |=> $stable(link_valid) && $stable(link_addr));

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_data)
                                        && $stable(mem_cmd_kind) && $stable(mem_cmd_last));

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  p_rsp_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

endmodule

bind linkreg_ctrl linkreg_ctrl_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready),
  .cpu_req_sc   (cpu_req_sc),
  .cpu_req_long (cpu_req_long),
  .cpu_req_addr (cpu_req_addr),
  .cpu_rsp_valid(cpu_rsp_valid),
  .mem_cmd_valid(mem_cmd_valid),
  .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_kind (mem_cmd_kind),
  .mem_cmd_data (mem_cmd_data),
  .mem_cmd_last (mem_cmd_last),
  .coh_inval    (coh_inval),
  .coh_update   (coh_update),
  .link_valid   (link_valid),
  .link_addr    (link_addr),
  .link_long    (link_long)
);

// File: tb/linkreg_ctrl_test.sv
module linkreg_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cpu_req_valid;
  logic        cpu_req_ready;
  logic        cpu_req_sc;
  logic        cpu_req_long;
  logic [31:0] cpu_req_addr;
  logic [63:0] cpu_req_wdata;
  logic        cpu_rsp_valid;
  logic [63:0] cpu_rsp_data;
  logic        mem_cmd_valid;
  logic        mem_cmd_ready;
  logic        mem_cmd_kind;
  logic [31:0] mem_cmd_addr;
  logic        mem_cmd_long;
  logic [31:0] mem_cmd_data;
  logic        mem_cmd_last;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        coh_inval;
  logic        coh_update;

  int checks;
  int failures;

  linkreg_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_sc(cpu_req_sc), .cpu_req_long(cpu_req_long),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_kind(mem_cmd_kind), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_long(mem_cmd_long), .mem_cmd_data(mem_cmd_data),
    .mem_cmd_last(mem_cmd_last),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .coh_inval(coh_inval), .coh_update(coh_update)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: backing memory and the link register
  logic [63:0] mem [logic [31:0]];
  bit          m_valid;
  logic [31:0] m_addr;
  bit          m_long;
  logic [63:0] m_data;

  function automatic logic [63:0] mem_get(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {~a, a ^ 32'h5a5a_0000};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic do_op(input bit sc, input bit lng, input logic [31:0] a,
                       input logic [63:0] wd, input int stall, input bit coh);
    logic [63:0] mv, exp_rsp, reply;
    logic [31:0] q_data[$];
    bit          q_last[$];
    bit          net, hit, ok, kind, done, rsp_sched, rsp_on, held;
    logic [31:0] held_data;
    int          cyc, stall_left;
    mv = mem_get(a);
    hit = m_valid && (m_addr == a) && (m_long == lng);
    net = 1'b0; kind = 1'b0; reply = '0;
    if (!sc) begin
      if (hit) begin
        exp_rsp = m_data;                         // R2
      end else begin
        net = 1'b1; kind = 1'b0;                  // R3
        exp_rsp = lng ? mv : {32'h0, mv[31:0]};
        m_valid = 1'b1; m_addr = a; m_long = lng; m_data = exp_rsp;
        q_data.push_back(32'h0); q_last.push_back(1'b1);
        reply = mv;
      end
    end else begin
      m_valid = 1'b0;                             // R6
      if (hit) begin
        net = 1'b1; kind = 1'b1;                  // R4
        q_data.push_back(m_data[31:0]); q_last.push_back(1'b0);
        if (lng) begin q_data.push_back(m_data[63:32]); q_last.push_back(1'b0); end
        q_data.push_back(wd[31:0]); q_last.push_back(!lng);
        if (lng) begin q_data.push_back(wd[63:32]); q_last.push_back(1'b1); end
        ok = lng ? (mv == m_data) : (mv[31:0] == m_data[31:0]);
        if (ok) mem[a] = lng ? wd : {mv[63:32], wd[31:0]};
        reply = {63'h0, !ok};
        exp_rsp = ok ? 64'd1 : 64'd0;             // R8
      end else begin
        exp_rsp = 64'd0;                          // R5
      end
    end

    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R10 ready when idle", {63'h0, cpu_req_ready}, 64'd1);
    cpu_req_valid = 1'b1; cpu_req_sc = sc; cpu_req_long = lng;
    cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;

    cyc = 1; done = 1'b0; rsp_sched = 1'b0; rsp_on = 1'b0; held = 1'b0;
    stall_left = stall; held_data = '0;
    while (!done && cyc < 60) begin
      if (rsp_on) begin mem_rsp_valid = 1'b0; rsp_on = 1'b0; end
      if (rsp_sched) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = reply; rsp_sched = 1'b0; rsp_on = 1'b1;
      end
      coh_inval  = coh && (cyc == 1);
      coh_update = coh && (cyc == 2);
      if (cpu_rsp_valid) begin
        chk(q_data.size() == 0, "R4 all flits sent before response", q_data.size(), 0);
        chk(cpu_rsp_data == exp_rsp, sc ? "R8 SC result" : "R3 LL data", cpu_rsp_data, exp_rsp);
        if (!net) chk(cyc == 1, sc ? "R5 local fail latency" : "R2 local hit latency", cyc, 1);
        done = 1'b1;
      end
      if (mem_cmd_valid) begin
        if (q_data.size() == 0) begin
          chk(1'b0, net ? "R9 extra command" : "R5 no command on local path", 64'd1, 64'd0);
          mem_cmd_ready = 1'b1;
        end else begin
          if (held) chk(mem_cmd_data == held_data, "R9 flit held under stall", mem_cmd_data, held_data);
          if (stall_left > 0) begin
            mem_cmd_ready = 1'b0; stall_left--; held = 1'b1; held_data = mem_cmd_data;
          end else begin
            mem_cmd_ready = 1'b1; held = 1'b0;
            chk(mem_cmd_kind == kind, "R4 command kind", mem_cmd_kind, kind);
            chk(mem_cmd_addr == a && mem_cmd_long == lng, "R4 command address and size",
                {mem_cmd_long, 31'h0, mem_cmd_addr}, {lng, 31'h0, a});
            chk(mem_cmd_data == q_data[0], "R4 flit payload", mem_cmd_data, q_data[0]);
            chk(mem_cmd_last == q_last[0], "R4 last flag", mem_cmd_last, q_last[0]);
            void'(q_data.pop_front()); void'(q_last.pop_front());
            if (q_data.size() == 0) rsp_sched = 1'b1;
          end
        end
      end else begin
        mem_cmd_ready = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk(done, "R10 response arrives", 64'd0, 64'd1);
    mem_cmd_ready = 1'b0; mem_rsp_valid = 1'b0; coh_inval = 1'b0; coh_update = 1'b0;
    chk(cpu_rsp_valid == 1'b0, "R10 single-cycle response", cpu_rsp_valid, 0);
    chk(cpu_req_ready == 1'b1, "R10 idle after response", cpu_req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    m_valid = 1'b0; m_addr = '0; m_long = 1'b0; m_data = '0;
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_sc = 1'b0; cpu_req_long = 1'b0;
    cpu_req_addr = '0; cpu_req_wdata = '0;
    mem_cmd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    coh_inval = 1'b0; coh_update = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R1 ready after reset", cpu_req_ready, 1);
    chk(cpu_rsp_valid == 1'b0, "R1 no response after reset", cpu_rsp_valid, 0);
    chk(mem_cmd_valid == 1'b0, "R1 no command after reset", mem_cmd_valid, 0);

    do_op(1, 0, 32'h100, 64'h1, 0, 0);                 // R5 SC with empty link
    do_op(0, 0, 32'h100, 64'h0, 0, 0);                 // R3 LL miss, upper masked
    do_op(0, 0, 32'h100, 64'h0, 0, 1);                 // R2 hit, coherence pulses
    repeat (2) begin
      @(negedge clk); coh_inval = 1'b1; coh_update = 1'b1;
      @(negedge clk); coh_inval = 1'b0; coh_update = 1'b0;
    end
    do_op(0, 0, 32'h100, 64'h0, 0, 0);                 // R7 link survives coherence
    do_op(1, 1, 32'h100, 64'h2, 0, 0);                 // R5 size mismatch
    do_op(1, 0, 32'h100, 64'h3, 0, 0);                 // R6 link already cleared
    do_op(0, 0, 32'h100, 64'h0, 0, 0);                 // R3 re-open
    do_op(1, 0, 32'h104, 64'h4, 0, 0);                 // R5 address mismatch
    do_op(0, 0, 32'h100, 64'h0, 0, 0);
    do_op(1, 0, 32'h100, 64'hdead_beef_0000_0007, 2, 0); // R4 R8 R9 short success
    do_op(0, 0, 32'h100, 64'h0, 0, 0);                 // R3 reads stored value
    do_op(0, 1, 32'h200, 64'h0, 1, 0);                 // R3 64-bit LL
    do_op(1, 1, 32'h200, 64'h1122_3344_5566_7788, 1, 0); // R4 4-flit success
    do_op(0, 1, 32'h200, 64'h0, 0, 0);
    mem[32'h200] = 64'h0bad_0bad_0bad_0bad;            // other writer changes memory
    do_op(1, 1, 32'h200, 64'h9, 0, 0);                 // R8 memory-side failure
    do_op(0, 1, 32'h300, 64'h0, 0, 0);
    do_op(0, 0, 32'h300, 64'h0, 0, 0);                 // R3 size change re-reads
    do_op(0, 0, 32'h300, 64'h0, 0, 0);                 // R2 hit at new size
    do_op(1, 0, 32'h300, 64'h55, 3, 0);                // R4 short success after stall
    summary();
    $finish;
  end

endmodule